// File: doc/BRIEF.md
# I2C Master Error Monitor

This block watches an I2C bus on behalf of a bus master and raises two sticky error flags. The first flag, arbitration lost, covers two cases. One is a START or STOP condition on the bus that this master did not generate. The other is a bus level read back on SDA that differs from the level the master meant to put there. The second flag, acknowledge error, is raised when the acknowledge bit after a byte is not the one the master expected.

The block takes the filtered SCL and SDA lines and the master's intended SDA level. It also takes a set of phase indicators from the master's sequencer:
- a transmitted bit is in progress,
- an address byte or a data byte is under way,
- the acknowledge slot is active,
- the master is generating a START or STOP itself.

While either flag is set, the block holds a start-inhibit output high. The master's sequencer must not issue a new START condition while that output is high. Software clears each flag separately with a write-one-to-clear pulse. A single configuration bit suppresses every acknowledge-class error.

Top module: `i2c_errmon`

## Requirements
- R1: With `mst_active` high and `gen_cond` low, an SDA falling edge or an SDA rising edge while SCL is high in two consecutive clock samples sets `arb_lost`. The flag is visible after the clock edge that samples the new SDA level. An SDA change while SCL is low has no effect.
- R2: At an SCL rising edge (SCL low in one sample and high in the next), with `mst_active` and `tx_bit` high, `sda_drive` = 1 and `sda_in` = 0 set `arb_lost`. When `sda_drive` = 0, no mismatch is ever reported.
- R3: At an SCL rising edge during `ack_slot` with `data_byte` high, an SDA level of 1 (not-acknowledge) sets `nack_err`.
- R4: At an SCL rising edge during `ack_slot` with `addr_byte` high and `expect_nack` = 0, an SDA level of 1 sets `nack_err`.
- R5: At an SCL rising edge during `ack_slot` with `addr_byte` high and `expect_nack` = 1, an SDA level of 0 (acknowledge) sets `nack_err`.
- R6: While `ignore_nack` = 1, the conditions of R3 to R5 do not set `nack_err`. Conditions that set `arb_lost` are not affected by this bit.
- R7: While `mst_active` = 0, no condition sets either flag.
- R8: Each flag stays set until a one-cycle pulse on its own clear input (`clr_arb` or `clr_nack`). A clear pulse leaves the other flag unchanged. A flag whose set condition and clear pulse arrive in the same cycle stays set.
- R9: `start_inhibit` is 1 exactly when at least one flag is set. It falls only in the cycle after a clear pulse.
- R10: After a synchronous active-low reset, `arb_lost`, `nack_err` and `start_inhibit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_active | input | 1 | Master is active; monitoring enabled |
| scl_in | input | 1 | Filtered SCL level |
| sda_in | input | 1 | Filtered SDA level |
| sda_drive | input | 1 | SDA level the master intends (1 = released/high) |
| tx_bit | input | 1 | Master is driving an address or data bit |
| addr_byte | input | 1 | Current byte is an address byte |
| data_byte | input | 1 | Current byte is a transmitted data byte |
| ack_slot | input | 1 | Acknowledge bit after the current byte |
| expect_nack | input | 1 | Address acknowledge expected to be NACK |
| gen_cond | input | 1 | Master is generating START or STOP itself |
| ignore_nack | input | 1 | Suppress acknowledge-class errors |
| clr_arb | input | 1 | Write-one-to-clear for `arb_lost` |
| clr_nack | input | 1 | Write-one-to-clear for `nack_err` |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| nack_err | output | 1 | Sticky acknowledge-error flag |
| start_inhibit | output | 1 | New START not permitted |

## Verification
The assertions rely on the bus lines held high (idle) through reset. This matters because the edge checks compare against the previous sample, and the block's own history registers reset to the idle level. The assertions also assume the phase indicators are stable across each SCL rising edge. The stimulus meets both assumptions:
- it keeps SCL and SDA at 1 during reset,
- it changes phase indicators and SDA only while SCL is low, except in the tests that create a START or STOP on purpose,
- it raises SCL in a step of its own.

// File: rtl/i2c_errmon_pkg.sv
// Package: shared flag indices and counts for the I2C error monitor.
// Assumes: two error flags; the index order sets the bit order of the flag vector.
package i2c_errmon_pkg;

    localparam int unsigned NUM_FLAGS = 2;

    typedef enum logic [0:0] {
        FLG_ARB  = 1'b0,
        FLG_NACK = 1'b1
    } flag_idx_e;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

endpackage

// File: rtl/i2c_errmon_cond_detect.sv
// Module: bus event detector. It keeps the previous SCL/SDA samples and
// reports an SCL rising edge and the bus START and STOP conditions.
// Assumes: the inputs are already filtered and synchronous to clk.
// The history registers reset to IDLE_LVL, the idle bus level.
module i2c_errmon_cond_detect #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic start_seen,
    output logic stop_seen
);

    logic scl_q;
    logic sda_q;

    // Purpose: store the previous bus sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= IDLE_LVL;
            sda_q <= IDLE_LVL;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Purpose: decode the edges from the current and previous samples.
    always_comb begin
        scl_rise   = scl_in & ~scl_q;
        start_seen = scl_in & scl_q & sda_q & ~sda_in;
        stop_seen  = scl_in & scl_q & ~sda_q & sda_in;
    end

endmodule

// File: rtl/i2c_errmon_arb.sv
// Module: arbitration-loss detection. It flags a foreign START/STOP (R1)
// and an SDA readback mismatch at an SCL rising edge while the master
// releases SDA high (R2).
// Assumes: gen_cond covers every cycle in which the master itself
// produces a START or STOP.
module i2c_errmon_arb (
    input  logic mst_active,
    input  logic gen_cond,
    input  logic tx_bit,
    input  logic sda_drive,
    input  logic sda_in,
    input  logic scl_rise,
    input  logic start_seen,
    input  logic stop_seen,
    output logic arb_set
);

    logic foreign_cond;
    logic readback_bad;

    // Purpose: combine both loss causes, gated by master activity (R7).
    always_comb begin
        foreign_cond = (start_seen | stop_seen) & ~gen_cond;
        readback_bad = scl_rise & tx_bit & sda_drive & ~sda_in;
        arb_set      = mst_active & (foreign_cond | readback_bad);
    end

endmodule

// File: rtl/i2c_errmon_ack.sv
// Module: acknowledge checking. At the SCL rising edge in the ack slot it
// compares the sampled ACK bit with the expected one (R3, R4, R5). The
// ignore bit masks the result (R6).
// Assumes: addr_byte and data_byte are not both high.
module i2c_errmon_ack (
    input  logic mst_active,
    input  logic ignore_nack,
    input  logic ack_slot,
    input  logic addr_byte,
    input  logic data_byte,
    input  logic expect_nack,
    input  logic sda_in,
    input  logic scl_rise,
    output logic nack_set
);

    logic got_nack;
    logic data_bad;
    logic addr_bad;

    // Purpose: decide whether the sampled acknowledge is the wrong one.
    always_comb begin
        got_nack = sda_in;
        data_bad = data_byte & got_nack;
        addr_bad = addr_byte & (expect_nack ? ~got_nack : got_nack);
        nack_set = mst_active & ~ignore_nack & scl_rise & ack_slot
                 & (data_bad | addr_bad);
    end

endmodule

// File: rtl/i2c_errmon_flag.sv
// Module: one sticky flag with write-one-to-clear. A set wins over a clear
// in the same cycle (R8).
// Assumes: clr is a one-cycle pulse from the register interface.
module i2c_errmon_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Purpose: hold the flag until cleared; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= set | (q & ~clr);
        end
    end

endmodule

// File: rtl/i2c_errmon.sv
// Module: I2C master error monitor top. It detects bus events, computes
// the error causes, holds the sticky flags and drives start_inhibit.
// Assumes: the bus inputs are filtered and synchronous. Phase indicators
// come from the master's sequencer and are stable across SCL rising edges.
module i2c_errmon
    import i2c_errmon_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mst_active,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sda_drive,
    input  logic tx_bit,
    input  logic addr_byte,
    input  logic data_byte,
    input  logic ack_slot,
    input  logic expect_nack,
    input  logic gen_cond,
    input  logic ignore_nack,
    input  logic clr_arb,
    input  logic clr_nack,
    output logic arb_lost,
    output logic nack_err,
    output logic start_inhibit
);

    logic      scl_rise;
    logic      start_seen;
    logic      stop_seen;
    logic      arb_set;
    logic      nack_set;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flag_vec;

    i2c_errmon_cond_detect #(.IDLE_LVL(IDLE_LVL)) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_rise   (scl_rise),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    i2c_errmon_arb u_arb (
        .mst_active (mst_active),
        .gen_cond   (gen_cond),
        .tx_bit     (tx_bit),
        .sda_drive  (sda_drive),
        .sda_in     (sda_in),
        .scl_rise   (scl_rise),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .arb_set    (arb_set)
    );

    i2c_errmon_ack u_ack (
        .mst_active  (mst_active),
        .ignore_nack (ignore_nack),
        .ack_slot    (ack_slot),
        .addr_byte   (addr_byte),
        .data_byte   (data_byte),
        .expect_nack (expect_nack),
        .sda_in      (sda_in),
        .scl_rise    (scl_rise),
        .nack_set    (nack_set)
    );

    // Purpose: pack the per-flag set and clear requests by index.
    always_comb begin
        set_vec           = '0;
        clr_vec           = '0;
        set_vec[FLG_ARB]  = arb_set;
        set_vec[FLG_NACK] = nack_set;
        clr_vec[FLG_ARB]  = clr_arb;
        clr_vec[FLG_NACK] = clr_nack;
    end

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        i2c_errmon_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_vec[gi]),
            .clr   (clr_vec[gi]),
            .q     (flag_vec[gi])
        );
    end

    // Purpose: drive the flag outputs and the START block (R9).
    always_comb begin
        arb_lost      = flag_vec[FLG_ARB];
        nack_err      = flag_vec[FLG_NACK];
        start_inhibit = |flag_vec;
    end

endmodule

// File: rtl/i2c_errmon_checker.sv
// Module: assertion checker for i2c_errmon, attached with bind.
// Assumes: the bus lines are high through reset.
module i2c_errmon_checker (
    input logic clk,
    input logic rst_n,
    input logic mst_active,
    input logic scl_in,
    input logic sda_in,
    input logic sda_drive,
    input logic tx_bit,
    input logic gen_cond,
    input logic ignore_nack,
    input logic clr_arb,
    input logic clr_nack,
    input logic arb_lost,
    input logic nack_err,
    input logic start_inhibit
);

    assert_foreign_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_active && !gen_cond && scl_in && $past(scl_in) && $past(sda_in) && !sda_in)
        |=> arb_lost);

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_active && tx_bit && sda_drive && scl_in && !$past(scl_in) && !sda_in)
        |=> arb_lost);

    assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ignore_nack && !nack_err) |=> !nack_err);

    assert_idle_arb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_active && !arb_lost) |=> !arb_lost);

    assert_idle_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_active && !nack_err) |=> !nack_err);

    assert_arb_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !clr_arb) |=> arb_lost);

    assert_nack_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_err && !clr_nack) |=> nack_err);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_arb && !mst_active) |=> !arb_lost);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_inhibit) |-> $past(clr_arb || clr_nack));

endmodule

bind i2c_errmon i2c_errmon_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mst_active    (mst_active),
    .scl_in        (scl_in),
    .sda_in        (sda_in),
    .sda_drive     (sda_drive),
    .tx_bit        (tx_bit),
    .gen_cond      (gen_cond),
    .ignore_nack   (ignore_nack),
    .clr_arb       (clr_arb),
    .clr_nack      (clr_nack),
    .arb_lost      (arb_lost),
    .nack_err      (nack_err),
    .start_inhibit (start_inhibit)
);

// File: tb/i2c_errmon_test.sv
module i2c_errmon_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mst_active = 1'b0, scl_in = 1'b1, sda_in = 1'b1, sda_drive = 1'b1;
    logic tx_bit = 1'b0, addr_byte = 1'b0, data_byte = 1'b0, ack_slot = 1'b0;
    logic expect_nack = 1'b0, gen_cond = 1'b0, ignore_nack = 1'b0;
    logic clr_arb = 1'b0, clr_nack = 1'b0;
    logic arb_lost, nack_err, start_inhibit;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_errmon uut (
        .clk(clk), .rst_n(rst_n), .mst_active(mst_active), .scl_in(scl_in),
        .sda_in(sda_in), .sda_drive(sda_drive), .tx_bit(tx_bit),
        .addr_byte(addr_byte), .data_byte(data_byte), .ack_slot(ack_slot),
        .expect_nack(expect_nack), .gen_cond(gen_cond), .ignore_nack(ignore_nack),
        .clr_arb(clr_arb), .clr_nack(clr_nack), .arb_lost(arb_lost),
        .nack_err(nack_err), .start_inhibit(start_inhibit)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_arb = 1'b1; clr_nack = 1'b1; step();
        clr_arb = 1'b0; clr_nack = 1'b0; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        chk("R10 arb", arb_lost, 1'b0);
        chk("R10 nack", nack_err, 1'b0);
        chk("R10 inh", start_inhibit, 1'b0);

        // R3 R4 R5 R6 R7: acknowledge sweep
        for (int c = 0; c < 32; c++) begin
            logic isdata, expn, ign, ackv, act, exp;
            isdata = c[0]; expn = c[1]; ign = c[2]; ackv = c[3]; act = c[4];
            exp = act & ~ign & (isdata ? ackv : (expn ? ~ackv : ackv));
            scl_in = 1'b0; step();
            mst_active = act; ignore_nack = ign; expect_nack = expn;
            data_byte = isdata; addr_byte = ~isdata; ack_slot = 1'b1;
            sda_in = ackv; step();
            scl_in = 1'b1; step();
            chk(isdata ? "R3 data ack" : (expn ? "R5 addr ack" : "R4 addr nack"),
                nack_err, exp);
            chk("R6 arb untouched", arb_lost, 1'b0);
            chk("R9 inhibit", start_inhibit, exp);
            scl_in = 1'b0; step();
            sda_in = 1'b1; ack_slot = 1'b0; data_byte = 1'b0; addr_byte = 1'b0;
            ignore_nack = 1'b0;
            clear_all();
            chk("R8 cleared", nack_err, 1'b0);
        end

        // R2 R7: readback sweep
        for (int c = 0; c < 16; c++) begin
            logic drv, line, tx, act, exp;
            drv = c[0]; line = c[1]; tx = c[2]; act = c[3];
            exp = act & tx & drv & ~line;
            scl_in = 1'b0; step();
            mst_active = act; tx_bit = tx; sda_drive = drv; sda_in = line; step();
            scl_in = 1'b1; step();
            chk("R2 readback", arb_lost, exp);
            chk("R2 no nack", nack_err, 1'b0);
            scl_in = 1'b0; step();
            sda_in = 1'b1; tx_bit = 1'b0; sda_drive = 1'b1;
            clear_all();
            chk("R8 cleared", arb_lost, 1'b0);
        end

        // R1 R6 R7: START and STOP with SCL high
        for (int c = 0; c < 8; c++) begin
            logic g, act, ign, exp;
            g = c[0]; act = c[1]; ign = c[2];
            exp = act & ~g;
            mst_active = act; gen_cond = g; ignore_nack = ign;
            scl_in = 1'b1; sda_in = 1'b1; step();
            sda_in = 1'b0; step();
            chk("R1 start", arb_lost, exp);
            clear_all();
            sda_in = 1'b1; step();
            chk("R1 stop", arb_lost, exp);
            clear_all();
            gen_cond = 1'b0; ignore_nack = 1'b0;
        end

        // R1: SDA toggling while SCL low is not a condition
        mst_active = 1'b1;
        scl_in = 1'b0; step();
        sda_in = 1'b0; step();
        sda_in = 1'b1; step();
        chk("R1 scl low", arb_lost, 1'b0);

        // R8 R9: stickiness and independent clears
        scl_in = 1'b1; step();
        sda_in = 1'b0; step();
        repeat (5) step();
        chk("R8 sticky", arb_lost, 1'b1);
        clr_nack = 1'b1; step(); clr_nack = 1'b0; step();
        chk("R8 other clear", arb_lost, 1'b1);
        scl_in = 1'b0; step();
        sda_in = 1'b1; data_byte = 1'b1; ack_slot = 1'b1; step();
        scl_in = 1'b1; clr_nack = 1'b1; step();
        clr_nack = 1'b0;
        chk("R8 set wins", nack_err, 1'b1);
        scl_in = 1'b0; data_byte = 1'b0; ack_slot = 1'b0; step();
        clr_arb = 1'b1; step(); clr_arb = 1'b0; step();
        chk("R8 arb cleared", arb_lost, 1'b0);
        chk("R8 nack kept", nack_err, 1'b1);
        chk("R9 still inhibited", start_inhibit, 1'b1);
        clr_nack = 1'b1; step(); clr_nack = 1'b0; step();
        chk("R9 released", start_inhibit, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule